// File: doc/BRIEF.md
# Three-Channel Gamma Lookup Table

This block applies a per-channel gamma curve to 8-bit RGB pixels in a compositor that drives three output channels. Each pixel comes in with the number of the output channel it belongs to. When that channel's gamma enable is set, each colour component is replaced by an entry from the channel's own curve. When the enable is clear, the component passes through unchanged. A result appears one clock after its pixel in both cases.

The curves sit in one flat, byte-wide table. Software loads it through two write ports. An address write sets a load pointer and chooses whether the pointer steps forward after each data write. Each data write then stores one byte at the pointer. The flat table gives each channel a span of 768 bytes, so channel c starts at byte c x 768. Inside a span the red curve (256 entries) comes first, then green, then blue. With auto-increment on, a whole channel, or the whole table, loads as one unbroken stream of data writes. The table contents may be lost while no channel has gamma enabled, so software reloads the curves before it sets an enable again.

Top module: `gamma_lut_top`

## Requirements
- R1: Flat table address A (0 to 2303) holds the entry for channel A / 768, colour (A mod 768) / 256 with 0 = red, 1 = green and 2 = blue, and input component value A mod 256.
- R2: An address write loads the pointer from `cfg_addr_wdata` and takes the auto-increment mode from `cfg_addr_autoinc`. An address of 2304 or more loads 0.
- R3: With auto-increment on, each data write stores `cfg_data_wdata` at the pointer, and the pointer then moves up by one.
- R4: With auto-increment off, a data write stores its byte but the pointer stays where it is, so repeated data writes overwrite the same entry and leave the next one alone.
- R5: With auto-increment on, a data write at address 2303 moves the pointer to address 0.
- R6: When an address write and a data write come in the same cycle, the byte goes to the pointer as it stood before that cycle. The pointer then takes the new address and does not step.
- R7: A valid pixel whose channel has its gamma enable set comes out one cycle later with each component replaced by that channel's table entry for the matching colour.
- R8: A valid pixel whose channel has its gamma enable clear comes out one cycle later with all three components unchanged.
- R9: A valid pixel with a channel number of 3 or more is passed through unchanged, whatever the enables are set to.
- R10: `pix_valid_o` equals `pix_valid_i` from one cycle earlier in both lookup and bypass modes, and it is 0 while reset is held and after reset.
- R11: The gamma enable is sampled in the same cycle as the pixel, so a change to the enable takes effect on the very next pixel.
- R12: A lookup of an entry in the same cycle that a data write stores to that entry returns the value the entry held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_we | input | 1 | Address write strobe |
| cfg_addr_wdata | input | 12 | Flat table address to load into the pointer |
| cfg_addr_autoinc | input | 1 | Auto-increment mode taken on an address write |
| cfg_data_we | input | 1 | Data write strobe |
| cfg_data_wdata | input | 8 | Byte to store at the pointer |
| gamma_en | input | 3 | Gamma enable for each channel |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_chan_i | input | 2 | Output channel of the input pixel |
| pix_r_i | input | 8 | Input red component |
| pix_g_i | input | 8 | Input green component |
| pix_b_i | input | 8 | Input blue component |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_r_o | output | 8 | Output red component |
| pix_g_o | output | 8 | Output green component |
| pix_b_o | output | 8 | Output blue component |

## Verification
The bench aims at the places where the pointer crosses a boundary: red to green, blue to the next channel, and the wrap from the last byte to zero. A design that carried wrongly there would write a curve into the wrong colour or channel, and that shows up as a wrong lookup. An address write and a data write in the same cycle, and an address past the end of the table, are tested on purpose. Getting the ordering wrong puts a byte at the new address, or drops it. A lookup in the same cycle as a write to the same entry must return the old value, while a channel number of 3 and enables that change on every pixel must bypass exactly when they should. A slip there returns a table byte in place of the raw component, or the reverse.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

  // Colour plane selected inside one channel span; order sets the layout.
  typedef enum logic [1:0] {
    COL_RED = 2'd0,
    COL_GRN = 2'd1,
    COL_BLU = 2'd2
  } color_e;

  localparam int unsigned NUM_COLORS = 3;

endpackage

// File: rtl/gamma_lut_rst_sync.sv
module gamma_lut_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/gamma_lut_ptr.sv
module gamma_lut_ptr
  import gamma_lut_pkg::*;
#(
  parameter int unsigned NUM_CH  = 3,
  parameter int unsigned COMP_W  = 8,
  parameter int unsigned CH_W    = 2,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              addr_autoinc,
  input  logic              data_we,
  output logic [CH_W-1:0]   ptr_ch,
  output color_e            ptr_col,
  output logic [COMP_W-1:0] ptr_idx,
  output logic              ptr_ai
);

  localparam int unsigned ENTRIES = 1 << COMP_W;
  localparam int unsigned CH_SPAN = NUM_COLORS * ENTRIES;
  localparam int unsigned TOTAL   = NUM_CH * CH_SPAN;

  logic [CH_W-1:0]   ch_q,  ch_d;
  color_e            col_q, col_d;
  logic [COMP_W-1:0] idx_q, idx_d;
  logic              ai_q,  ai_d;
  logic              ptr_en;

  // Decomposition of a flat address into channel / colour / index.
  logic [CH_W-1:0]   ld_ch;
  logic [ADDR_W-1:0] ld_rem;
  color_e            ld_col;
  logic [COMP_W-1:0] ld_idx;
  logic              ld_ok;

  always_comb begin
    ld_ok  = (addr_wdata < ADDR_W'(TOTAL));
    ld_ch  = '0;
    ld_rem = addr_wdata;
    for (int c = 1; c < int'(NUM_CH); c++) begin
      if (addr_wdata >= ADDR_W'(c * CH_SPAN)) begin
        ld_ch  = CH_W'(c);
        ld_rem = addr_wdata - ADDR_W'(c * CH_SPAN);
      end
    end
    if (!ld_ok) begin
      ld_ch  = '0;
      ld_rem = '0;
    end
    ld_col = color_e'(ld_rem[COMP_W+1:COMP_W]);
    ld_idx = ld_rem[COMP_W-1:0];
  end

  // Next-state: address load wins over stepping.
  always_comb begin
    ch_d  = ch_q;
    col_d = col_q;
    idx_d = idx_q;
    ai_d  = ai_q;
    if (addr_we) begin
      ch_d  = ld_ch;
      col_d = ld_col;
      idx_d = ld_idx;
      ai_d  = addr_autoinc;
    end else if (data_we && ai_q) begin
      if (idx_q == {COMP_W{1'b1}}) begin
        idx_d = '0;
        if (col_q == COL_BLU) begin
          col_d = COL_RED;
          if (ch_q == CH_W'(NUM_CH - 1)) begin
            ch_d = '0;
          end else begin
            ch_d = ch_q + 1'b1;
          end
        end else begin
          col_d = color_e'(col_q + 2'd1);
        end
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  assign ptr_en = addr_we | (data_we & ai_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q  <= '0;
      col_q <= COL_RED;
      idx_q <= '0;
      ai_q  <= 1'b0;
    end else if (ptr_en) begin
      ch_q  <= ch_d;
      col_q <= col_d;
      idx_q <= idx_d;
      ai_q  <= ai_d;
    end
  end

  assign ptr_ch  = ch_q;
  assign ptr_col = col_q;
  assign ptr_idx = idx_q;
  assign ptr_ai  = ai_q;

endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank #(
  parameter int unsigned DEPTH = 768,
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  // Single write, single registered read; a read in the write cycle sees old data.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata_q <= mem[raddr];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
  import gamma_lut_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned COMP_W = 8,
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1,
  localparam int unsigned ENTRIES = 1 << COMP_W,
  localparam int unsigned CH_SPAN = NUM_COLORS * ENTRIES,
  localparam int unsigned TOTAL   = NUM_CH * CH_SPAN,
  localparam int unsigned ADDR_W  = $clog2(TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_addr_we,
  input  logic [ADDR_W-1:0] cfg_addr_wdata,
  input  logic              cfg_addr_autoinc,
  input  logic              cfg_data_we,
  input  logic [COMP_W-1:0] cfg_data_wdata,
  input  logic [NUM_CH-1:0] gamma_en,
  input  logic              pix_valid_i,
  input  logic [CH_W-1:0]   pix_chan_i,
  input  logic [COMP_W-1:0] pix_r_i,
  input  logic [COMP_W-1:0] pix_g_i,
  input  logic [COMP_W-1:0] pix_b_i,
  output logic              pix_valid_o,
  output logic [COMP_W-1:0] pix_r_o,
  output logic [COMP_W-1:0] pix_g_o,
  output logic [COMP_W-1:0] pix_b_o
);

  localparam int unsigned BANK_DEPTH = NUM_CH * ENTRIES;
  localparam int unsigned BANK_AW    = CH_W + COMP_W;

  logic              rst_sync_n;
  logic [CH_W-1:0]   ptr_ch;
  color_e            ptr_col;
  logic [COMP_W-1:0] ptr_idx;
  logic              ptr_ai;

  logic [COMP_W-1:0] comp_in  [NUM_COLORS];
  logic [COMP_W-1:0] comp_lut [NUM_COLORS];
  logic [COMP_W-1:0] comp_out [NUM_COLORS];
  logic [COMP_W-1:0] byp_q    [NUM_COLORS];

  logic en_sel;
  logic lut_hit;
  logic valid_q, valid_d;
  logic lut_q,   lut_d;

  gamma_lut_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gamma_lut_ptr #(
    .NUM_CH (NUM_CH),
    .COMP_W (COMP_W),
    .CH_W   (CH_W),
    .ADDR_W (ADDR_W)
  ) u_ptr (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .addr_we      (cfg_addr_we),
    .addr_wdata   (cfg_addr_wdata),
    .addr_autoinc (cfg_addr_autoinc),
    .data_we      (cfg_data_we),
    .ptr_ch       (ptr_ch),
    .ptr_col      (ptr_col),
    .ptr_idx      (ptr_idx),
    .ptr_ai       (ptr_ai)
  );

  assign comp_in[0] = pix_r_i;
  assign comp_in[1] = pix_g_i;
  assign comp_in[2] = pix_b_i;

  // Enable of the pixel's channel; channel numbers past the last one bypass.
  always_comb begin
    en_sel = 1'b0;
    for (int c = 0; c < int'(NUM_CH); c++) begin
      if (pix_chan_i == CH_W'(c)) begin
        en_sel = gamma_en[c];
      end
    end
  end

  assign lut_hit = pix_valid_i & en_sel;

  for (genvar k = 0; k < int'(NUM_COLORS); k++) begin : g_bank
    logic bank_we;
    assign bank_we = cfg_data_we & (ptr_col == color_e'(2'(k)));

    gamma_lut_bank #(
      .DEPTH (BANK_DEPTH),
      .AW    (BANK_AW),
      .DW    (COMP_W)
    ) u_bank (
      .clk   (clk),
      .we    (bank_we),
      .waddr ({ptr_ch, ptr_idx}),
      .wdata (cfg_data_wdata),
      .re    (lut_hit),
      .raddr ({pix_chan_i, comp_in[k]}),
      .rdata (comp_lut[k])
    );

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        byp_q[k] <= '0;
      end else if (pix_valid_i) begin
        byp_q[k] <= comp_in[k];
      end
    end

    assign comp_out[k] = lut_q ? comp_lut[k] : byp_q[k];
  end

  always_comb begin
    valid_d = pix_valid_i;
    lut_d   = lut_hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      lut_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      lut_q   <= lut_d;
    end
  end

  assign pix_valid_o = valid_q;
  assign pix_r_o     = comp_out[0];
  assign pix_g_o     = comp_out[1];
  assign pix_b_o     = comp_out[2];

endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_addr_we,
  input logic              cfg_data_we,
  input logic [NUM_CH-1:0] gamma_en,
  input logic              pix_valid_i,
  input logic [CH_W-1:0]   pix_chan_i,
  input logic [COMP_W-1:0] pix_r_i,
  input logic [COMP_W-1:0] pix_g_i,
  input logic [COMP_W-1:0] pix_b_i,
  input logic              pix_valid_o,
  input logic [COMP_W-1:0] pix_r_o,
  input logic [COMP_W-1:0] pix_g_o,
  input logic [COMP_W-1:0] pix_b_o,
  input logic [CH_W-1:0]   ptr_ch,
  input logic [1:0]        ptr_col,
  input logic [COMP_W-1:0] ptr_idx,
  input logic              ptr_ai
);

  localparam int unsigned ENTRIES = 1 << COMP_W;
  localparam int unsigned CH_SPAN = 3 * ENTRIES;
  localparam int unsigned TOTAL   = NUM_CH * CH_SPAN;

  logic [31:0] flat;
  logic        chan_oor;
  logic        chan_off;

  assign flat     = 32'(ptr_ch) * CH_SPAN + 32'(ptr_col) * ENTRIES + 32'(ptr_idx);
  assign chan_oor = (32'(pix_chan_i) >= NUM_CH);
  assign chan_off = !chan_oor && !gamma_en[pix_chan_i[CH_W-1:0] % NUM_CH];

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_i |=> pix_valid_o); // R10
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid_i |=> !pix_valid_o); // R10
  AST_BYPASS_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_i && chan_off) |=> (pix_r_o == $past(pix_r_i) && pix_g_o == $past(pix_g_i) && pix_b_o == $past(pix_b_i))); // R8
  AST_OOR_CHAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_i && chan_oor) |=> (pix_r_o == $past(pix_r_i) && pix_g_o == $past(pix_g_i) && pix_b_o == $past(pix_b_i))); // R9
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_data_we && !cfg_addr_we && !ptr_ai) |=> $stable(flat)); // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_data_we && !cfg_addr_we && ptr_ai && flat != TOTAL - 1) |=> (flat == $past(flat) + 1)); // R3
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_data_we && !cfg_addr_we && ptr_ai && flat == TOTAL - 1) |=> (flat == 0)); // R5
  AST_PTR_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (flat < TOTAL) && (ptr_col != 2'd3)); // R1

endmodule

bind gamma_lut_top gamma_lut_chk #(
  .NUM_CH (NUM_CH),
  .COMP_W (COMP_W),
  .CH_W   (CH_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cfg_addr_we (cfg_addr_we),
  .cfg_data_we (cfg_data_we),
  .gamma_en    (gamma_en),
  .pix_valid_i (pix_valid_i),
  .pix_chan_i  (pix_chan_i),
  .pix_r_i     (pix_r_i),
  .pix_g_i     (pix_g_i),
  .pix_b_i     (pix_b_i),
  .pix_valid_o (pix_valid_o),
  .pix_r_o     (pix_r_o),
  .pix_g_o     (pix_g_o),
  .pix_b_o     (pix_b_o),
  .ptr_ch      (ptr_ch),
  .ptr_col     (ptr_col),
  .ptr_idx     (ptr_idx),
  .ptr_ai      (ptr_ai)
);

// File: tb/gamma_lut_top_tb_top.sv
module gamma_lut_top_tb_top;

  localparam int TOTAL = 2304;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_addr_we;
  logic [11:0] cfg_addr_wdata;
  logic        cfg_addr_autoinc;
  logic        cfg_data_we;
  logic [7:0]  cfg_data_wdata;
  logic [2:0]  gamma_en;
  logic        pix_valid_i;
  logic [1:0]  pix_chan_i;
  logic [7:0]  pix_r_i, pix_g_i, pix_b_i;
  logic        pix_valid_o;
  logic [7:0]  pix_r_o, pix_g_o, pix_b_o;

  logic [7:0] mdl [TOTAL];
  int  mptr;
  bit  mai;
  int  nchk;
  int  nfail;
  bit  done;

  always #5 clk = ~clk;

  gamma_lut_top dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_addr_we      (cfg_addr_we),
    .cfg_addr_wdata   (cfg_addr_wdata),
    .cfg_addr_autoinc (cfg_addr_autoinc),
    .cfg_data_we      (cfg_data_we),
    .cfg_data_wdata   (cfg_data_wdata),
    .gamma_en         (gamma_en),
    .pix_valid_i      (pix_valid_i),
    .pix_chan_i       (pix_chan_i),
    .pix_r_i          (pix_r_i),
    .pix_g_i          (pix_g_i),
    .pix_b_i          (pix_b_i),
    .pix_valid_o      (pix_valid_o),
    .pix_r_o          (pix_r_o),
    .pix_g_o          (pix_g_o),
    .pix_b_o          (pix_b_o)
  );

  // Expected component per R1/R7/R8/R9.
  function automatic int exp_comp(int ch, int col, int v, logic [2:0] en);
    if (ch < 3 && en[ch]) return int'(mdl[ch * 768 + col * 256 + v]);
    return v;
  endfunction

  task automatic check(string req, int act, int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // One cycle of stimulus, driven at a falling edge, checked at the next one.
  task automatic step(bit aw, int a, bit ai, bit dw, int d,
                      bit pv, int ch, int r, int g, int b, string req);
    int er, eg, eb;
    cfg_addr_we      = aw;
    cfg_addr_wdata   = 12'(a);
    cfg_addr_autoinc = ai;
    cfg_data_we      = dw;
    cfg_data_wdata   = 8'(d);
    pix_valid_i      = pv;
    pix_chan_i       = 2'(ch);
    pix_r_i          = 8'(r);
    pix_g_i          = 8'(g);
    pix_b_i          = 8'(b);
    er = exp_comp(ch, 0, r, gamma_en);
    eg = exp_comp(ch, 1, g, gamma_en);
    eb = exp_comp(ch, 2, b, gamma_en);
    if (dw) mdl[mptr] = 8'(d);
    if (aw) begin
      mptr = (a >= TOTAL) ? 0 : a;
      mai  = ai;
    end else if (dw && mai) begin
      mptr = (mptr + 1) % TOTAL;
    end
    @(posedge clk);
    @(negedge clk);
    cfg_addr_we = 1'b0;
    cfg_data_we = 1'b0;
    pix_valid_i = 1'b0;
    check({req, " valid"}, int'(pix_valid_o), int'(pv));
    if (pv) begin
      check({req, " red"},   int'(pix_r_o), er);
      check({req, " green"}, int'(pix_g_o), eg);
      check({req, " blue"},  int'(pix_b_o), eb);
    end
  endtask

  task automatic addr_wr(int a, bit ai, string req);
    step(1'b1, a, ai, 1'b0, 0, 1'b0, 0, 0, 0, 0, req);
  endtask

  task automatic data_wr(int d, string req);
    step(1'b0, 0, 1'b0, 1'b1, d, 1'b0, 0, 0, 0, 0, req);
  endtask

  task automatic look(int ch, int r, int g, int b, string req);
    step(1'b0, 0, 1'b0, 1'b0, 0, 1'b1, ch, r, g, b, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    nchk = 0; nfail = 0; done = 0; mptr = 0; mai = 0;
    rst_n = 1'b0;
    cfg_addr_we = 0; cfg_addr_wdata = '0; cfg_addr_autoinc = 0;
    cfg_data_we = 0; cfg_data_wdata = '0; gamma_en = '0;
    pix_valid_i = 0; pix_chan_i = '0; pix_r_i = '0; pix_g_i = '0; pix_b_i = '0;
    for (int i = 0; i < TOTAL; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", int'(pix_valid_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 idle valid", int'(pix_valid_o), 0);

    // R3: fill the whole table in one auto-increment stream.
    addr_wr(0, 1'b1, "R2 load");
    for (int i = 0; i < TOTAL; i++) data_wr(int'($urandom_range(255)), "R3 fill");

    // R1 / R7: boundary component values on every channel.
    gamma_en = 3'b111;
    for (int c = 0; c < 3; c++) begin
      look(c, 0, 0, 0, "R7 low");
      look(c, 255, 255, 255, "R7 high");
      look(c, 17, 128, 254, "R1 mixed");
    end

    // R8: enables clear give identity.
    gamma_en = 3'b000;
    for (int c = 0; c < 3; c++) look(c, 3, 200, 91, "R8 bypass");

    // R9: channel number 3 bypasses even with all enables set.
    gamma_en = 3'b111;
    look(3, 44, 55, 66, "R9 oor chan");

    // R11: enable changes on consecutive pixels.
    gamma_en = 3'b001; look(0, 10, 20, 30, "R11 on");
    gamma_en = 3'b110; look(0, 10, 20, 30, "R11 off");
    gamma_en = 3'b010; look(1, 10, 20, 30, "R11 ch1 on");
    gamma_en = 3'b111;

    // R2: out-of-range address loads 0; mid-table address lands in green of channel 1.
    addr_wr(3000, 1'b1, "R2 oor");
    data_wr(8'h5A, "R2 oor write");
    look(0, 0, 1, 1, "R2 oor entry");
    addr_wr(768 + 256 + 17, 1'b1, "R2 mid");
    data_wr(8'hC3, "R2 mid write");
    look(1, 5, 17, 5, "R2 mid entry");

    // R4: no auto-increment keeps the pointer; next entry untouched.
    addr_wr(1000, 1'b0, "R4 load");
    data_wr(11, "R4 write1");
    data_wr(22, "R4 write2");
    look(1, 232, 0, 0, "R4 same entry");
    look(1, 233, 0, 0, "R4 next entry");

    // R5: wrap from the last byte to the first.
    addr_wr(TOTAL - 1, 1'b1, "R5 load");
    data_wr(7, "R5 last");
    data_wr(9, "R5 wrapped");
    look(2, 0, 0, 255, "R5 last entry");
    look(0, 0, 0, 0, "R5 first entry");

    // Colour and channel carries inside the auto-increment stream.
    addr_wr(255, 1'b1, "R3 carry load");
    data_wr(101, "R3 red end");
    data_wr(102, "R3 green start");
    look(0, 255, 0, 0, "R3 red end");
    look(0, 0, 0, 0, "R3 green start");
    addr_wr(767, 1'b1, "R3 chan carry load");
    data_wr(103, "R3 chan end");
    data_wr(104, "R3 chan next");
    look(0, 0, 0, 255, "R3 chan end");
    look(1, 0, 0, 0, "R3 chan next");

    // R6: address and data write in the same cycle.
    addr_wr(500, 1'b1, "R6 load");
    step(1'b1, 1500, 1'b1, 1'b1, 77, 1'b0, 0, 0, 0, 0, "R6 both");
    data_wr(88, "R6 follow");
    look(0, 0, 244, 0, "R6 old pointer");
    look(1, 0, 0, 220, "R6 new pointer");

    // R12: lookup and write of the same entry in one cycle.
    addr_wr(5, 1'b0, "R12 load");
    step(1'b0, 0, 1'b0, 1'b1, 8'hEE, 1'b1, 0, 5, 5, 5, "R12 same cycle");
    look(0, 5, 5, 5, "R12 after write");

    // Random mix of loads, writes, pixels and enables.
    for (int i = 0; i < 3000; i++) begin
      bit aw, dw, pv;
      aw = ($urandom_range(9) == 0);
      dw = ($urandom_range(9) < 4);
      pv = ($urandom_range(9) < 7);
      if ($urandom_range(7) == 0) gamma_en = 3'($urandom_range(7));
      step(aw, int'($urandom_range(2400)), 1'($urandom_range(1)), dw,
           int'($urandom_range(255)), pv, int'($urandom_range(3)),
           int'($urandom_range(255)), int'($urandom_range(255)),
           int'($urandom_range(255)), "R7 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule